// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Sub-Bus Flag Cascade

This block collects sixteen interrupt request lines into one sticky status register and presents a single interrupt to the processor. The output is high whenever a status bit is set and its mask bit is also set. Software reads the status, mask and sub-bus flag registers over a simple memory-mapped port. It clears status and flag bits by writing ones to them. A write to the mask flips each mask bit that is written as 1, rather than loading the mask.

Four timer requests are merged onto request lines 9 to 12. Two sub-bus sources set sparse bits in a separate flag register. While any flag is set, that register drives request line 1. A sub-bus event therefore appears first as a flag and then as status bit 1. All status and flag bits record rising edges and stay set until software clears them. Reads have no side effects.

Top module: `irq_aggregator`

## Requirements
- R1: The status register is at address 0xF000 and the mask register at 0xF010, both in data bits 15:0. The sub-bus flag register is at 0xF230. `rdata` shows the selected register in the same cycle as `rd_en`. Any other address reads as zero, and a write to it changes no register.
- R2: A rising edge on the effective request of line n (0..15) sets status bit n at the next clock edge. Status bits are sticky: when the request falls, the bit stays set.
- R3: Writing the status register clears each status bit written as 1. A bit whose request rises in the same cycle as the write stays set. A request that is still high after its bit is cleared does not set the bit again.
- R4: Writing the mask register XORs the written data into the mask.
- R5: `irq_o` is high exactly when (status AND mask) is nonzero. It follows register updates without added delay.
- R6: A rising edge on sub-bus source 0 sets flag bit 8. A rising edge on sub-bus source 1 sets flag bit 10. No other flag bit ever reads as 1.
- R7: Writing the flag register clears each flag bit written as 1. A flag whose source rises in the same cycle stays set.
- R8: The effective request of line 1 is `req_i[1]` OR (any flag set). When a flag becomes set, status bit 1 sets one cycle later.
- R9: Timer input k (0..3) is ORed into the effective request of line 9+k.
- R10: Reading any register leaves every register unchanged.
- R11: After reset, status, mask and flags are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Level requests for lines 0..15 |
| tmr_i | input | 4 | Timer requests, merged onto lines 9..12 |
| sub_i | input | 2 | Sub-bus interrupt sources |
| addr | input | 16 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The hardest cases to reach from the ports are collisions between a clear and a new event. One is a status or flag write that lands in the same cycle as a fresh rising edge. The other is a clear issued while the request line is still held high. The bench creates both by driving the request change and the write strobe on the same falling edge. It then reads back whether the bit survived.

The cascade has its own hard case: status bit 1 can only be set again after every flag has been cleared and a flag has then been set again. The bench reaches this with a clear–reclear–re-pulse sequence on the sub-bus inputs.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int N_LINES      = 16,
  parameter int N_TMR        = 4,
  parameter int TMR_BASE     = 9,
  parameter int CASCADE_LINE = 1,
  parameter int N_SUB        = 2,
  parameter int FLAG_BASE    = 8,
  parameter int FLAG_STEP    = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF000,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hF010,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hF230
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_TMR-1:0]  tmr_i,
  input  logic [N_SUB-1:0]  sub_i,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);

  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASCADE_LINE;

  logic [N_LINES-1:0] stat_q, mask_q, prev_q, tmr_line, line_req, rise, wlo;
  logic [N_SUB-1:0]   subf_q, sub_prev_q, sub_rise, sub_clr;
  logic [DATA_W-1:0]  flag_view;
  logic               wr_stat, wr_mask, wr_flag;

  assign wlo     = wdata[N_LINES-1:0];
  assign wr_stat = wr_en && (addr == STAT_ADDR);
  assign wr_mask = wr_en && (addr == MASK_ADDR);
  assign wr_flag = wr_en && (addr == FLAG_ADDR);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (i >= TMR_BASE && i < TMR_BASE + N_TMR) begin : g_tmr
      assign tmr_line[i] = tmr_i[i-TMR_BASE];
    end else begin : g_none
      assign tmr_line[i] = 1'b0;
    end
  end

  for (genvar k = 0; k < N_SUB; k++) begin : g_sub
    assign sub_clr[k] = wdata[FLAG_BASE + FLAG_STEP*k];
  end

  always_comb begin
    flag_view = '0;
    for (int k = 0; k < N_SUB; k++) flag_view[FLAG_BASE + FLAG_STEP*k] = subf_q[k];
  end

  assign line_req = req_i | tmr_line | ({N_LINES{|subf_q}} & CASC_BIT);
  assign rise     = line_req & ~prev_q;
  assign sub_rise = sub_i & ~sub_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= '0;
      mask_q     <= '0;
      prev_q     <= '0;
      subf_q     <= '0;
      sub_prev_q <= '0;
    end else begin
      prev_q     <= line_req;
      sub_prev_q <= sub_i;
      stat_q     <= (wr_stat ? (stat_q & ~wlo) : stat_q) | rise;
      subf_q     <= (wr_flag ? (subf_q & ~sub_clr) : subf_q) | sub_rise;
      if (wr_mask) mask_q <= mask_q ^ wlo;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == STAT_ADDR)      rdata[N_LINES-1:0] = stat_q;
      else if (addr == MASK_ADDR) rdata[N_LINES-1:0] = mask_q;
      else if (addr == FLAG_ADDR) rdata = flag_view;
    end
  end

  assign irq_o = |(stat_q & mask_q);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stat) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stat) |-> ((stat_q & $past(wlo) & ~$past(rise)) == '0));

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_mask) |-> (mask_q == ($past(mask_q) ^ $past(wlo))));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stat && (wlo == '1) && (rise == '0)) |-> !irq_o);

  p_flag_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flag_view) <= N_SUB);

  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_flag) |-> ((subf_q & $past(sub_clr) & ~$past(sub_rise)) == '0));

  p_cascade_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|subf_q) && !prev_q[CASCADE_LINE]) |=> stat_q[CASCADE_LINE]);

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic [3:0]  tmr_i = '0;
  logic [1:0]  sub_i = '0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] A_ST = 16'hF000, A_MK = 16'hF010, A_FL = 16'hF230;

  always #5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .tmr_i(tmr_i), .sub_i(sub_i),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulse_req(input int n);
    @(negedge clk); req_i[n] = 1'b1;
    @(negedge clk); req_i[n] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ST, v); chk("R11 status after reset", v, 0);
    rd(A_MK, v); chk("R11 mask after reset", v, 0);
    rd(A_FL, v); chk("R11 flags after reset", v, 0);
    chk("R11 irq after reset", {31'd0, irq_o}, 0);
  endtask

  task automatic t_edge_sticky();
    logic [31:0] v;
    pulse_req(3);
    rd(A_ST, v); chk("R2 sticky after pulse", v, 32'h0008);
    @(negedge clk); req_i[5] = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_ST, v); chk("R2 held request", v, 32'h0028);
    chk("R5 masked off irq low", {31'd0, irq_o}, 0);
    req_i[5] = 1'b0;
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_MK, 32'h00F0); rd(A_MK, v); chk("R4 first toggle", v, 32'h00F0);
    wr(A_MK, 32'h0030); rd(A_MK, v); chk("R4 second toggle", v, 32'h00C0);
    chk("R5 no overlap irq low", {31'd0, irq_o}, 0);
    wr(A_MK, 32'h0020);
    chk("R5 overlap irq high", {31'd0, irq_o}, 1);
  endtask

  task automatic t_read_noclear();
    logic [31:0] v;
    rd(A_ST, v); rd(A_ST, v); chk("R10 status after reads", v, 32'h0028);
    rd(A_FL, v); rd(A_MK, v); chk("R10 mask after reads", v, 32'h00E0);
    chk("R10 irq kept", {31'd0, irq_o}, 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(A_ST, 32'h0020); rd(A_ST, v); chk("R3 partial clear", v, 32'h0008);
    chk("R5 irq drops", {31'd0, irq_o}, 0);
    wr(A_ST, 32'h0008); rd(A_ST, v); chk("R3 full clear", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    req_i[7] = 1'b1; addr = A_ST; wdata = 32'h0080; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(A_ST, v); chk("R3 set wins over clear", v, 32'h0080);
    wr(A_ST, 32'h0080); rd(A_ST, v); chk("R3 held level no reset", v, 0);
    req_i[7] = 1'b0;
  endtask

  task automatic t_sub();
    logic [31:0] v;
    @(negedge clk); sub_i[0] = 1'b1;
    @(negedge clk); sub_i[0] = 1'b0;
    rd(A_FL, v); chk("R6 source0 flag bit 8", v, 32'h0100);
    rd(A_ST, v); chk("R8 cascade sets line1", v, 32'h0002);
    @(negedge clk); sub_i[1] = 1'b1;
    @(negedge clk); sub_i[1] = 1'b0;
    rd(A_FL, v); chk("R6 source1 flag bit 10", v, 32'h0500);
    wr(A_FL, 32'h0100); rd(A_FL, v); chk("R7 clear bit 8", v, 32'h0400);
    wr(A_ST, 32'h0002); rd(A_ST, v); chk("R8 line1 high no reset", v, 0);
    wr(A_FL, 32'h0400); rd(A_FL, v); chk("R7 clear bit 10", v, 0);
    @(negedge clk); sub_i[0] = 1'b1;
    @(negedge clk); sub_i[0] = 1'b0;
    @(negedge clk);
    rd(A_ST, v); chk("R8 cascade re-fires", v, 32'h0002);
    @(negedge clk);
    sub_i[1] = 1'b1; addr = A_FL; wdata = 32'h0500; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sub_i[1] = 1'b0;
    rd(A_FL, v); chk("R7 flag set wins", v, 32'h0400);
    wr(A_FL, 32'h0400); wr(A_ST, 32'h0002);
    rd(A_ST, v); chk("R8 cleared", v, 0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    @(negedge clk); tmr_i[2] = 1'b1;
    @(negedge clk); tmr_i[2] = 1'b0;
    rd(A_ST, v); chk("R9 timer2 to line 11", v, 32'h0800);
    @(negedge clk); tmr_i[0] = 1'b1;
    @(negedge clk); tmr_i[0] = 1'b0;
    rd(A_ST, v); chk("R9 timer0 to line 9", v, 32'h0A00);
    wr(A_ST, 32'hFFFF);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    pulse_req(4);
    rd(16'hF004, v); chk("R1 unmapped read zero", v, 0);
    wr(16'hF020, 32'hFFFF);
    rd(A_ST, v); chk("R1 unmapped write status", v, 32'h0010);
    rd(A_MK, v); chk("R1 unmapped write mask", v, 32'h00E0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge_sticky();
    t_mask();
    t_read_noclear();
    t_clear();
    t_collide();
    t_sub();
    t_timer();
    t_addr();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule